// File: doc/BRIEF.md
# Bus Master Transfer Response Controller

This block is the master-side controller for one system bus cycle. A local requester hands it a read or write request: an address, byte enables, write data, a direction and a burst flag. The block drives the address, data and direction onto the bus, along with two data-buffer enables: one for the input path and one for the output path. It then waits for the slave to answer on three response lines: wait, address-hold and last.

The bus clock arrives as a phase input on a faster system clock. While the bus clock is low, the block keeps the most recent response. On the system clock edge where the bus clock is first seen high, it acts on the kept value, so anything on the response lines during the high phase is ignored. A wait or address-hold answer keeps every bus output frozen. A ready or last answer closes the beat, captures read data and sends a one-cycle done pulse. In a burst, a ready answer moves on to the next word, and a last answer closes the burst. A reserved code, or a fall from address-hold back into plain wait, sets a sticky error flag. The beat is then closed as though the answer were ready, so the bus cannot hang.

Top module: `busRespMaster`

## Requirements
- R1: Response code {respWait,respHold,respLast}=000 (ready) closes the current beat. A non-burst transfer then returns to idle (busy low), and done is high for the one system cycle after the sampling edge.
- R2: Code 001 (last) closes the beat and the burst. busy drops and done pulses, even when the request was a burst.
- R3: While the sampled code is 100 (wait) or 110 (address hold), busAddr, busBe, busWdata and busWrite keep the values loaded at the start, and done stays low. A reqValid pulse while busy is not accepted.
- R4: Every code other than 000, 001, 100 and 110 sets respErr and closes the beat as if it were ready.
- R5: A 100 code sampled after a 110 code in the same beat sets respErr and closes the beat as if it were ready.
- R6: Values on the response lines while busClk is high have no effect. Only the last value seen while busClk was low is acted on, at the first system edge with busClk high.
- R7: While busy, busWrite is high for a write and low for a read. dinEn is high only on an active read, doutEn is high only on an active write, and the two are never high together.
- R8: On a read, rdData takes busRdata at the closing sampling edge. It is valid in the same cycle as the done pulse.
- R9: respErr stays set until errClr is asserted or reset is applied.
- R10: In a burst, a ready code advances busAddr by the number of byte lanes (4), loads busWdata from reqWdata and keeps busy high.
- R11: After reset: busy, done, busWrite, dinEn, doutEn and respErr are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| busClk | input | 1 | Bus clock level, used as a phase input |
| reqValid | input | 1 | Request strobe, accepted only when idle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqBurst | input | 1 | Request is a burst |
| reqAddr | input | ADDR_W | Start address |
| reqBe | input | DATA_W/8 | Byte enables |
| reqWdata | input | DATA_W | Write data (first word at start, next word at each burst step) |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle beat completion pulse |
| rdData | output | DATA_W | Captured read data |
| busAddr | output | ADDR_W | Bus address |
| busBe | output | DATA_W/8 | Bus byte enables |
| busWdata | output | DATA_W | Bus write data |
| busWrite | output | 1 | Transfer direction, high on write |
| dinEn | output | 1 | Data input buffer enable |
| doutEn | output | 1 | Data output buffer enable |
| busRdata | input | DATA_W | Read data from the slave |
| respWait | input | 1 | Slave wait response line |
| respHold | input | 1 | Slave address-hold response line |
| respLast | input | 1 | Slave last response line |
| errClr | input | 1 | Clears the sticky error flag |
| respErr | output | 1 | Sticky protocol error flag |

## Verification
A table of single transfers runs reads and writes with zero to three wait periods, each delivered as either plain wait or address hold. During every high phase the response lines carry the ready code, so a stall that is cut short shows that the high phase is not being ignored. Directed runs cover a read burst and a write burst, to separate beat advance from burst end. A reserved code and a hold-then-wait sequence are run to check that errors close the beat. An error is then carried across a clean transfer and cleared, to show that the flag is sticky. A reqValid pulse is also issued during a stall, to show that requests are not taken while busy.

// File: rtl/busRespPkg.sv
package busRespPkg;
  localparam logic [2:0] RESP_READY = 3'b000;
  localparam logic [2:0] RESP_LAST  = 3'b001;
  localparam logic [2:0] RESP_WAIT  = 3'b100;
  localparam logic [2:0] RESP_HOLD  = 3'b110;

  typedef enum logic {ST_IDLE, ST_ACTIVE} ctrlState_t;

  typedef struct packed {
    logic load;      // take a new request
    logic nextBeat;  // advance to the next burst word
    logic capture;   // register read data
    logic active;    // a cycle is on the bus
  } dpStrobe_t;
endpackage

// File: rtl/busRespCtrl.sv
module busRespCtrl
  import busRespPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      busClk,
  input  logic      reqValid,
  input  logic      respWait,
  input  logic      respHold,
  input  logic      respLast,
  input  logic      errClr,
  input  logic      isWrite,
  input  logic      isBurst,
  output dpStrobe_t strobe,
  output logic      done,
  output logic      respErr
);
  ctrlState_t state, stateNext;
  logic       busClkQ;
  logic [2:0] respKept;
  logic       inHold;
  logic       sampleEn;
  logic       isReady, isLast, isWait, isHoldCode, isResv;
  logic       badSeq, endBeat, protoErr, stayOn;

  // Keep the last response seen in the low phase; ignore the high phase.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      busClkQ  <= 1'b1;
      respKept <= RESP_WAIT;
    end else begin
      busClkQ <= busClk;
      if (!busClk) respKept <= {respWait, respHold, respLast};
    end
  end

  always_comb begin
    sampleEn   = busClk && !busClkQ && (state == ST_ACTIVE);
    isReady    = (respKept == RESP_READY);
    isLast     = (respKept == RESP_LAST);
    isWait     = (respKept == RESP_WAIT);
    isHoldCode = (respKept == RESP_HOLD);
    isResv     = !(isReady || isLast || isWait || isHoldCode);
    badSeq     = isWait && inHold;
    protoErr   = sampleEn && (isResv || badSeq);
    endBeat    = sampleEn && (isReady || isLast || isResv || badSeq);
    stayOn     = isBurst && !isLast;

    strobe.load     = (state == ST_IDLE) && reqValid;
    strobe.nextBeat = endBeat && stayOn;
    strobe.capture  = endBeat && !isWrite;
    strobe.active   = (state == ST_ACTIVE);

    stateNext = state;
    if (strobe.load)             stateNext = ST_ACTIVE;
    else if (endBeat && !stayOn) stateNext = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      inHold  <= 1'b0;
      done    <= 1'b0;
      respErr <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= endBeat;
      if (strobe.load || endBeat)    inHold <= 1'b0;
      else if (sampleEn && isHoldCode) inHold <= 1'b1;
      if (protoErr)    respErr <= 1'b1;
      else if (errClr) respErr <= 1'b0;
    end
  end
endmodule

// File: rtl/busRespDatapath.sv
module busRespDatapath
  import busRespPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int BE_W  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic              reqWrite,
  input  logic              reqBurst,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [BE_W-1:0]   reqBe,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] busRdata,
  output logic              isWrite,
  output logic              isBurst,
  output logic [ADDR_W-1:0] busAddr,
  output logic [BE_W-1:0]   busBe,
  output logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] rdData,
  output logic              busWrite,
  output logic              dinEn,
  output logic              doutEn
);
  localparam logic [ADDR_W-1:0] BEAT_STEP = ADDR_W'(BE_W);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busAddr  <= '0;
      busBe    <= '0;
      busWdata <= '0;
      rdData   <= '0;
      isWrite  <= 1'b0;
      isBurst  <= 1'b0;
    end else begin
      if (strobe.load) begin
        busAddr  <= reqAddr;
        busBe    <= reqBe;
        busWdata <= reqWdata;
        isWrite  <= reqWrite;
        isBurst  <= reqBurst;
      end else if (strobe.nextBeat) begin
        busAddr  <= busAddr + BEAT_STEP;
        busWdata <= reqWdata;
      end
      if (strobe.capture) rdData <= busRdata;
    end
  end

  always_comb begin
    busWrite = strobe.active && isWrite;
    doutEn   = strobe.active && isWrite;
    dinEn    = strobe.active && !isWrite;
  end
endmodule

// File: rtl/busRespMaster.sv
module busRespMaster
  import busRespPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int BE_W  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busClk,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              reqBurst,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [BE_W-1:0]   reqBe,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] busAddr,
  output logic [BE_W-1:0]   busBe,
  output logic [DATA_W-1:0] busWdata,
  output logic              busWrite,
  output logic              dinEn,
  output logic              doutEn,
  input  logic [DATA_W-1:0] busRdata,
  input  logic              respWait,
  input  logic              respHold,
  input  logic              respLast,
  input  logic              errClr,
  output logic              respErr
);
  dpStrobe_t strobe;
  logic      isWrite, isBurst;

  busRespCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .busClk(busClk), .reqValid(reqValid),
    .respWait(respWait), .respHold(respHold), .respLast(respLast),
    .errClr(errClr), .isWrite(isWrite), .isBurst(isBurst),
    .strobe(strobe), .done(done), .respErr(respErr)
  );

  busRespDatapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .reqWrite(reqWrite), .reqBurst(reqBurst), .reqAddr(reqAddr),
    .reqBe(reqBe), .reqWdata(reqWdata), .busRdata(busRdata),
    .isWrite(isWrite), .isBurst(isBurst),
    .busAddr(busAddr), .busBe(busBe), .busWdata(busWdata),
    .rdData(rdData), .busWrite(busWrite), .dinEn(dinEn), .doutEn(doutEn)
  );

  assign busy = strobe.active;
endmodule

// File: rtl/busRespChecker.sv
module busRespChecker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              done,
  input logic              respErr,
  input logic              errClr,
  input logic              dinEn,
  input logic              doutEn,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr
);
  AST_DONE_AFTER_ACTIVE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(busy)); // R1

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && !done) |-> $stable(busAddr)); // R3

  AST_DIR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(busWrite)); // R7

  AST_EN_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(dinEn && doutEn)); // R7

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R8

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (respErr && !errClr) |=> respErr); // R9
endmodule

bind busRespMaster busRespChecker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .done(done), .respErr(respErr),
  .errClr(errClr), .dinEn(dinEn), .doutEn(doutEn), .busWrite(busWrite),
  .busAddr(busAddr)
);

// File: tb/busRespMaster_tb.sv
module busRespMaster_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busClk = 1'b1;
  logic        reqValid = 1'b0, reqWrite = 1'b0, reqBurst = 1'b0;
  logic [31:0] reqAddr = '0, reqWdata = '0, busRdata = '0;
  logic [3:0]  reqBe = '0;
  logic        respWait = 1'b1, respHold = 1'b0, respLast = 1'b0, errClr = 1'b0;
  logic        busy, done, busWrite, dinEn, doutEn, respErr;
  logic [31:0] rdData, busAddr, busWdata;
  logic [3:0]  busBe;

  int total = 0, bad = 0, cycles = 0;

  always #2 clk = ~clk; // 250 MHz

  busRespMaster u_dut (.*);

  typedef struct packed {
    logic        wr;
    logic [31:0] addr;
    logic [3:0]  be;
    logic [31:0] data;
    logic [1:0]  nWait;
    logic        useHold;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b0, 32'h0000_1000, 4'hF, 32'hA5A5_0001, 2'd0, 1'b0},
    '{1'b1, 32'h0000_2004, 4'h3, 32'h1234_5678, 2'd1, 1'b0},
    '{1'b0, 32'h0000_3008, 4'hC, 32'hDEAD_BEEF, 2'd2, 1'b1},
    '{1'b1, 32'h0000_400C, 4'h1, 32'hCAFE_F00D, 2'd3, 1'b1},
    '{1'b0, 32'hFFFF_FFFC, 4'h8, 32'h0BAD_CAFE, 2'd3, 1'b0},
    '{1'b1, 32'h8000_0000, 4'hF, 32'h5555_AAAA, 2'd2, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic startReq(input logic wr, input logic bst, input logic [31:0] a,
                          input logic [3:0] b, input logic [31:0] d);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqBurst = bst; reqAddr = a; reqBe = b; reqWdata = d;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  // One bus period: 2 cycles low with code lo, then high with code hi.
  // Returns just after the sampling edge.
  task automatic busPeriod(input logic [2:0] lo, input logic [2:0] hi);
    @(negedge clk);
    busClk = 1'b0; {respWait, respHold, respLast} = lo;
    @(negedge clk);
    @(negedge clk);
    busClk = 1'b1; {respWait, respHold, respLast} = hi;
    @(negedge clk);
  endtask

  task automatic finish();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      finish();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 busy", busy, 0); chk("R11 done", done, 0); chk("R11 busWrite", busWrite, 0);
    chk("R11 dinEn", dinEn, 0); chk("R11 doutEn", doutEn, 0); chk("R11 respErr", respErr, 0);
    rstN = 1'b1;

    // Table walk: single transfers with waits or holds (R1 R3 R6 R7 R8)
    foreach (VECS[i]) begin
      busRdata = ~VECS[i].data;
      startReq(VECS[i].wr, 1'b0, VECS[i].addr, VECS[i].be, VECS[i].data);
      chk("R7 busWrite", busWrite, VECS[i].wr);
      chk("R7 dinEn", dinEn, !VECS[i].wr);
      chk("R7 doutEn", doutEn, VECS[i].wr);
      for (int w = 0; w < VECS[i].nWait; w++) begin
        // R6: high phase drives ready, which must be ignored
        busPeriod(VECS[i].useHold ? 3'b110 : 3'b100, 3'b000);
        chk("R3 busy", busy, 1); chk("R3 done", done, 0);
        chk("R3 busAddr", busAddr, VECS[i].addr);
        chk("R3 busBe", {28'd0, busBe}, {28'd0, VECS[i].be});
        chk("R3 busWdata", busWdata, VECS[i].data);
        chk("R6 busWrite held", busWrite, VECS[i].wr);
      end
      busPeriod(3'b000, 3'b100);
      chk("R1 done", done, 1); chk("R1 busy", busy, 0);
      if (!VECS[i].wr) chk("R8 rdData", rdData, ~VECS[i].data);
      chk("R1 respErr", respErr, 0);
      @(negedge clk);
      chk("R8 done one cycle", done, 0);
    end

    // R3: request while busy is not taken
    startReq(1'b0, 1'b0, 32'h0000_0100, 4'hF, 32'h0);
    busPeriod(3'b100, 3'b100);
    @(negedge clk); reqValid = 1'b1; reqAddr = 32'h0000_0900; reqWrite = 1'b1;
    @(negedge clk); reqValid = 1'b0;
    chk("R3 addr ignores req", busAddr, 32'h0000_0100);
    chk("R3 dir ignores req", busWrite, 0);
    busPeriod(3'b000, 3'b000);
    chk("R1 done after stall", done, 1);

    // R10 / R2: read burst
    busRdata = 32'h1111_0000;
    startReq(1'b0, 1'b1, 32'h0000_5000, 4'hF, 32'h0);
    busPeriod(3'b000, 3'b000);
    chk("R10 done beat1", done, 1); chk("R10 busy beat1", busy, 1);
    chk("R10 addr step", busAddr, 32'h0000_5004);
    chk("R8 rd beat1", rdData, 32'h1111_0000);
    busRdata = 32'h2222_0000;
    busPeriod(3'b100, 3'b000);
    chk("R10 wait in burst", busAddr, 32'h0000_5004);
    busPeriod(3'b001, 3'b000);
    chk("R2 done last", done, 1); chk("R2 busy last", busy, 0);
    chk("R8 rd last", rdData, 32'h2222_0000);

    // R10 write burst data reload
    startReq(1'b1, 1'b1, 32'h0000_6000, 4'hF, 32'hAAAA_0000);
    chk("R10 first word", busWdata, 32'hAAAA_0000);
    reqWdata = 32'hBBBB_0001;
    busPeriod(3'b000, 3'b000);
    chk("R10 next word", busWdata, 32'hBBBB_0001);
    chk("R10 next addr", busAddr, 32'h0000_6004);
    busPeriod(3'b001, 3'b001);
    chk("R2 write burst end", busy, 0);

    // R4 reserved code
    startReq(1'b0, 1'b0, 32'h0000_7000, 4'hF, 32'h0);
    busPeriod(3'b010, 3'b000);
    chk("R4 respErr", respErr, 1); chk("R4 done", done, 1); chk("R4 busy", busy, 0);

    // R9 sticky across a clean transfer
    startReq(1'b1, 1'b0, 32'h0000_7100, 4'hF, 32'h0);
    busPeriod(3'b000, 3'b000);
    chk("R9 sticky", respErr, 1);
    @(negedge clk); errClr = 1'b1;
    @(negedge clk); errClr = 1'b0;
    chk("R9 cleared", respErr, 0);

    // R5 hold then wait
    startReq(1'b0, 1'b0, 32'h0000_8000, 4'hF, 32'h0);
    busPeriod(3'b110, 3'b000);
    chk("R5 hold no err", respErr, 0); chk("R5 hold busy", busy, 1);
    busPeriod(3'b100, 3'b000);
    chk("R5 respErr", respErr, 1); chk("R5 done", done, 1); chk("R5 busy", busy, 0);

    // R9 reset clears
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    chk("R9 reset clears", respErr, 0);

    finish();
  end
endmodule